// File: doc/BRIEF.md
# UART Receive Buffer with Character Status

This block sits between a UART's serial receiver and the register interface. Every time the receiver finishes a character, it offers the data byte together with three per-character flags: line break, missing stop bit, and a third flag. The third flag carries a parity error in normal operation and the received address/data marker in multidrop operation. The block keeps these characters in a small first-in first-out store, three entries deep by default. Behind that store sits a one-character holding stage. The holding stage absorbs one further arrival when the store is full.

An 8-bit status byte reports the state of the buffer. It gives the flags of the character at the head of the store, a sticky overrun indication, store-full and data-available indications, and two transmitter indications that are passed through unchanged. A read strobe pops the head character into a read-data register. An error-clear command strobe wipes the reported error state without consuming data.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After reset every bit of the status byte is 0 (with both transmitter inputs low), and the read-data register is 0.
- R2: Status bit 0 (data available) is 1 exactly when the store holds at least one character. Status bit 1 (store full) is 1 exactly when it holds DEPTH characters.
- R3: Characters leave the store in arrival order. Each entry keeps its own flags. Status bits 7, 6 and 5 show the break, stop-bit and parity flags of the head entry.
- R4: While the store is empty, status bits 7, 6 and 5 are 0.
- R5: An arrival that finds the store full, or the holding stage occupied, is placed in the holding stage. When the store has room, the waiting character enters the store at the next clock edge, so a pop at one edge lets the store be full again one edge later.
- R6: An arrival while the store is full and the holding stage is occupied sets status bit 4 (overrun). The waiting character is then lost together with its flags, and the new arrival takes its place.
- R7: The error-clear command clears status bit 4. It also forces bits 7 and 6, and bit 5 outside multidrop mode, to 0 until the head character changes. If a new overrun occurs in the same cycle as the command, the overrun wins.
- R8: A read while data is available pops the head. Its data byte appears on the read-data port after that clock edge. Any read also clears status bit 4.
- R9: A read while the store is empty leaves the read-data port and the character count unchanged.
- R10: In multidrop mode, status bit 5 shows the head entry's address/data marker, and the error-clear command does not hide it.
- R11: Status bits 3 and 2 follow the transmitter-empty and transmitter-ready inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| md_mode | input | 1 | Multidrop mode: flag 5 is the address/data marker |
| rx_valid | input | 1 | One-cycle strobe: a finished character is offered |
| rx_data | input | 8 | Received data byte |
| rx_brk | input | 1 | Character was a line break |
| rx_ferr | input | 1 | Stop bit missing |
| rx_pflag | input | 1 | Parity error, or address/data marker in multidrop mode |
| rd_en | input | 1 | Read strobe for the receive buffer |
| err_clr | input | 1 | Error-clear command strobe |
| tx_empty | input | 1 | Transmitter empty, passed to status bit 3 |
| tx_ready | input | 1 | Transmitter ready, passed to status bit 2 |
| rd_data | output | 8 | Last character popped from the store |
| status | output | 8 | Status byte {brk, ferr, perr, ovr, txemp, txrdy, full, rdy} |

## Verification
The assertions watch, on every cycle, the relations between the status bits:
- head flags are zero while the store is empty;
- full implies data available;
- overrun is raised by the full-plus-waiting arrival and dropped by a clear command;
- an empty read leaves the read data unchanged;
- a waiting character drains as soon as the store has room.

Only the bench's scenarios can show the rest:
- arrival order through the store and the holding stage;
- that the lost character is the older waiting one and not the new arrival;
- that masked flags come back with the next head character;
- that multidrop keeps the marker visible across a clear.

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          md_mode,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_brk,
  input  logic          rx_ferr,
  input  logic          rx_pflag,
  input  logic          rd_en,
  input  logic          err_clr,
  input  logic          tx_empty,
  input  logic          tx_ready,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status
);
  localparam int EW = DW + 3;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [EW-1:0] hold;
  logic          hold_v;
  logic          ovr, sup;

  logic          full, nempty, pop, push, ovr_ev;
  logic [EW-1:0] arr, push_ent, head;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign arr      = {rx_brk, rx_ferr, rx_pflag, rx_data};
  assign full     = (cnt == CW'(DEPTH));
  assign nempty   = (cnt != '0);
  assign pop      = rd_en && nempty;
  assign push     = !full && (hold_v || rx_valid);
  assign push_ent = hold_v ? hold : arr;
  assign ovr_ev   = rx_valid && hold_v && full;
  assign head     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      hold    <= '0;
      hold_v  <= 1'b0;
      ovr     <= 1'b0;
      sup     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (push) begin
        mem[wp] <= push_ent;
        wp      <= nxt(wp);
      end
      if (pop) begin
        rp      <= nxt(rp);
        rd_data <= head[DW-1:0];
      end
      cnt <= cnt + CW'(push) - CW'(pop);

      if (rx_valid && (hold_v || full)) begin
        hold   <= arr;
        hold_v <= 1'b1;
      end else if (hold_v && !full) begin
        hold_v <= 1'b0;
      end

      if (ovr_ev)                ovr <= 1'b1;
      else if (rd_en || err_clr) ovr <= 1'b0;

      if (pop || !nempty) sup <= 1'b0;
      else if (err_clr)   sup <= 1'b1;
    end
  end

  assign status[7] = nempty && !sup && head[EW-1];
  assign status[6] = nempty && !sup && head[EW-2];
  assign status[5] = nempty && (md_mode || !sup) && head[EW-3];
  assign status[4] = ovr;
  assign status[3] = tx_empty;
  assign status[2] = tx_ready;
  assign status[1] = full;
  assign status[0] = nempty;
endmodule

module uart_rx_fifo_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rd_en,
  input logic          err_clr,
  input logic          hold_v,
  input logic [DW-1:0] rd_data,
  input logic [7:0]    status
);
  a_r4_flags_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> (status[7:5] == 3'b000));

  a_r2_full_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);

  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && hold_v && status[1]) |=> status[4]);

  a_r7_clear_drops_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(rx_valid && hold_v && status[1])) |=> !status[4]);

  a_r9_empty_read_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !status[0]) |=> $stable(rd_data));

  a_r5_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !status[1] && !rx_valid) |=> !hold_v);

  a_r6_overrun_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(rx_valid));
endmodule

bind uart_rx_fifo_status uart_rx_fifo_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_en(rd_en),
  .err_clr(err_clr), .hold_v(hold_v), .rd_data(rd_data), .status(status)
);

// File: tb/tb_uart_rx_fifo_status.sv
module tb_uart_rx_fifo_status;
  localparam int DEPTH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic md_mode = 0, rx_valid = 0, rx_brk = 0, rx_ferr = 0, rx_pflag = 0;
  logic rd_en = 0, err_clr = 0, tx_empty = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] rd_data, status;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_fifo_status #(.DEPTH(DEPTH), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .md_mode(md_mode), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_pflag(rx_pflag),
    .rd_en(rd_en), .err_clr(err_clr), .tx_empty(tx_empty), .tx_ready(tx_ready),
    .rd_data(rd_data), .status(status)
  );

  // reference model: entries packed {brk, ferr, pflag, data}
  logic [10:0] q[$];
  logic [10:0] m_hold;
  bit m_hv, m_ovr, m_sup;
  logic [7:0] m_rdd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_hv = 0; m_ovr = 0; m_sup = 0; m_rdd = 0; m_hold = 0;
    end else begin
      int sz;
      bit fl, pp;
      logic [10:0] a;
      sz = q.size();
      fl = (sz == DEPTH);
      pp = rd_en && sz > 0;
      a  = {rx_brk, rx_ferr, rx_pflag, rx_data};
      if (pp) begin m_rdd = q[0][7:0]; void'(q.pop_front()); end
      if (!fl && m_hv) q.push_back(m_hold);
      else if (!fl && rx_valid) q.push_back(a);
      if (rx_valid && fl && m_hv) m_ovr = 1;
      else if (rd_en || err_clr) m_ovr = 0;
      if (pp || sz == 0) m_sup = 0;
      else if (err_clr) m_sup = 1;
      if (rx_valid && (m_hv || fl)) begin m_hold = a; m_hv = 1; end
      else if (m_hv && !fl) m_hv = 0;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ne;
    logic [10:0] h;
    ne = q.size() > 0;
    h = ne ? q[0] : 11'd0;
    chk("R2 ready/full", {6'd0, status[1:0]}, {6'd0, q.size() == DEPTH, ne});
    chk("R3 head flags", {5'd0, status[7:5]},
        {5'd0, ne && !m_sup && h[10], ne && !m_sup && h[9], ne && (md_mode || !m_sup) && h[8]});
    chk("R6 overrun", {7'd0, status[4]}, {7'd0, m_ovr});
    chk("R11 tx bits", {6'd0, status[3:2]}, {6'd0, tx_empty, tx_ready});
    chk("R8 read data", rd_data, m_rdd);
  endtask

  task automatic cyc(bit rv, logic [7:0] d, bit b, bit f, bit p, bit rd, bit er);
    rx_valid = rv; rx_data = d; rx_brk = b; rx_ferr = f; rx_pflag = p;
    rd_en = rd; err_clr = er;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    idle();
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset rd_data", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3: fill store
    cyc(1, 8'h11, 1, 0, 0, 0, 0);
    chk("R3 head break", status, 8'h81);
    cyc(1, 8'h22, 0, 1, 0, 0, 0);
    cyc(1, 8'h33, 0, 0, 1, 0, 0);
    chk("R2 full", status & 8'h03, 8'h03);
    // R5 / R6: one waits, next overruns
    cyc(1, 8'h44, 0, 0, 0, 0, 0);
    chk("R5 waits no overrun", status & 8'h10, 8'h00);
    cyc(1, 8'h55, 0, 0, 0, 0, 0);
    chk("R6 overrun set", status & 8'h10, 8'h10);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R8 first pop", rd_data, 8'h11);
    chk("R8 read clears overrun", status & 8'h10, 8'h00);
    chk("R5 slot free after pop", status & 8'h02, 8'h00);
    chk("R3 next head ferr", status & 8'he0, 8'h40);
    idle();
    chk("R5 waiting char entered", status & 8'h02, 8'h02);
    cyc(0, 0, 0, 0, 0, 1, 0); chk("R3 order", rd_data, 8'h22);
    cyc(0, 0, 0, 0, 0, 1, 0); chk("R3 order", rd_data, 8'h33);
    cyc(0, 0, 0, 0, 0, 1, 0); chk("R6 lost char skipped", rd_data, 8'h55);
    chk("R4 empty flags", status & 8'he1, 8'h00);
    // R9
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R9 empty read data", rd_data, 8'h55);
    chk("R9 empty read count", status & 8'h03, 8'h00);

    // R7
    cyc(1, 8'h66, 1, 1, 1, 0, 0);
    cyc(1, 8'h77, 0, 1, 0, 0, 0);
    chk("R7 flags before clear", status & 8'he0, 8'he0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R7 flags hidden", status & 8'he0, 8'h00);
    chk("R7 data kept", status & 8'h01, 8'h01);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R7 next head flags shown", status & 8'he0, 8'h40);
    drain();

    // R10
    md_mode = 1;
    cyc(1, 8'h88, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R10 marker survives clear", status & 8'he0, 8'h20);
    drain();
    md_mode = 0;

    // R11
    tx_empty = 1; idle();
    chk("R11 tx empty", status & 8'h0c, 8'h08);
    tx_empty = 0; tx_ready = 1; idle();
    chk("R11 tx ready", status & 8'h0c, 8'h04);

    // R7 clear with overrun in same cycle: overrun wins
    for (int i = 0; i < 4; i++) cyc(1, 8'(i), 0, 0, 0, 0, 0);
    cyc(1, 8'h99, 0, 0, 0, 0, 1);
    chk("R7 overrun beats clear", status & 8'h10, 8'h10);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R7 clear drops overrun", status & 8'h10, 8'h00);
    drain();

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      if (i % 1000 == 0) md_mode = ~md_mode;
      tx_empty = $urandom_range(0, 1);
      cyc(($urandom_range(0, 9) < 4), 8'($urandom), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 1),
          ($urandom_range(0, 9) < ((i / 500) % 2 ? 2 : 5)), ($urandom_range(0, 19) == 0));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule